// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block keeps the error-confinement standing of a CAN node. It holds a transmit error counter and a receive error counter, moves them up or down on single-cycle strobes from the protocol engine, and derives from their values whether the node may take full part in bus traffic (error-active), may only signal errors passively (error-passive), or must stay off the bus entirely (bus-off). Which protocol events cause which strobes is decided outside this block.

Once the node is bus-off, the counters freeze. The block then watches the sampled bus level on every bit strobe. It counts runs of eleven consecutive recessive bits. After the one hundred and twenty-eighth such run, both counters return to zero and the node becomes error-active again. A level output flags that either counter has reached the warning level. One-cycle pulses mark the moments when the warning level, the error-passive state and the bus-off state are entered, so that an interrupt unit can latch them.

Top module: `can_fault_confine`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to error-active with both counters at zero, `warn` low and all three pulse outputs low. The state encoding is error-active = 2'b00, error-passive = 2'b01 and bus-off = 2'b10.
- R2: Outside bus-off, an increment strobe alone raises its counter by one at the next edge, and a decrement strobe alone lowers it by one. When both strobes are high together, the counter does not change. A decrement at zero leaves the counter at zero.
- R3: The receive counter stops at 255 and does not wrap when incremented further.
- R4: From error-active, the node moves to error-passive at the edge where either counter becomes greater than 127.
- R5: From error-passive, the node returns to error-active at the edge where both counters are 127 or less.
- R6: The node enters bus-off at the edge where the transmit counter becomes greater than 255.
- R7: While the node is bus-off, increment and decrement strobes have no effect on either counter.
- R8: In bus-off, every bit strobe with `bus_level` high (recessive) extends the current run. Every eleventh consecutive recessive bit completes a run. At the edge of the bit strobe that completes the 128th run, the node becomes error-active with both counters at zero. Clock cycles without a bit strobe neither extend nor break a run.
- R9: In bus-off, a bit strobe with `bus_level` low (dominant) restarts the current run from zero but keeps the number of runs already completed.
- R10: `warn` is high exactly while either counter is 96 or more. It changes at the same edge as the counters.
- R11: `warn_rise`, `passive_rise` and `busoff_rise` are each high for the single cycle in which `warn` or the state first shows the newly entered condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_err_inc | input | 1 | Raise the transmit error counter by one |
| tx_err_dec | input | 1 | Lower the transmit error counter by one |
| rx_err_inc | input | 1 | Raise the receive error counter by one |
| rx_err_dec | input | 1 | Lower the receive error counter by one |
| bit_tick | input | 1 | One-cycle strobe per sampled bus bit |
| bus_level | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| conf_state | output | 2 | Confinement state (00 active, 01 passive, 10 bus-off) |
| tx_errs | output | TEC_W (9) | Transmit error counter |
| rx_errs | output | REC_W (8) | Receive error counter |
| warn | output | 1 | Either counter is at or above the warning level |
| warn_rise | output | 1 | Pulse on entering the warning level |
| passive_rise | output | 1 | Pulse on entering error-passive |
| busoff_rise | output | 1 | Pulse on entering bus-off |

## Verification
The assertions assume that the reset is held for at least two edges, so that every `$past` sample after it refers to a defined state. They also assume that strobes change only between edges. They do not assume that increment and decrement strobes are exclusive. The random stimulus therefore drives all four strobes independently, including both at once and decrements at zero, and drives them on the falling edge after at least three reset cycles. Its bias toward increments and toward recessive bits makes it pass through error-passive, bus-off and full recovery several times.

// File: rtl/fc_pkg.sv
package fc_pkg;
   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'b00,
      FC_PASSIVE = 2'b01,
      FC_BUSOFF  = 2'b10
   } fc_state_e;
endpackage

// File: rtl/fc_err_counter.sv
// Saturating up/down error counter with clear and freeze controls.
module fc_err_counter #(
   parameter int W   = 8,
   parameter int MAX = (1 << W) - 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         hold,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] cnt_d
);
   localparam logic [W-1:0] TOP = W'(MAX);
   localparam logic [W-1:0] ONE = W'(1);

   always_comb begin
      cnt_d = cnt_q;
      if (clr) begin
         cnt_d = '0;
      end else if (!hold) begin
         if (inc && !dec && cnt_q != TOP)
            cnt_d = cnt_q + ONE;
         else if (dec && !inc && cnt_q != '0)
            cnt_d = cnt_q - ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_d;
   end
endmodule

// File: rtl/fc_idle_tracker.sv
// Counts runs of consecutive recessive bits while armed (bus-off).
module fc_idle_tracker #(
   parameter int RUN_BITS  = 11,
   parameter int RUN_COUNT = 128
) (
   input  logic clk,
   input  logic rst,
   input  logic arm,
   input  logic bit_tick,
   input  logic recessive,
   output logic done
);
   localparam int BW = $clog2(RUN_BITS + 1);
   localparam int CW = $clog2(RUN_COUNT + 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(RUN_BITS - 1);
   localparam logic [CW-1:0] LAST_RUN = CW'(RUN_COUNT - 1);

   logic [BW-1:0] bit_q;
   logic [CW-1:0] run_q;
   logic          run_end;

   assign run_end = bit_tick && recessive && (bit_q == LAST_BIT);
   assign done    = arm && run_end && (run_q == LAST_RUN);

   always_ff @(posedge clk) begin
      if (rst || !arm || done) begin
         bit_q <= '0;
         run_q <= '0;
      end else if (bit_tick) begin
         if (!recessive) begin
            bit_q <= '0;
         end else if (run_end) begin
            bit_q <= '0;
            run_q <= run_q + CW'(1);
         end else begin
            bit_q <= bit_q + BW'(1);
         end
      end
   end
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine #(
   parameter int TEC_W         = 9,
   parameter int REC_W         = 8,
   parameter int WARN_LEVEL    = 96,
   parameter int PASSIVE_LIMIT = 127,
   parameter int BUSOFF_LIMIT  = 255,
   parameter int RUN_BITS      = 11,
   parameter int RUN_COUNT     = 128
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tx_err_inc,
   input  logic             tx_err_dec,
   input  logic             rx_err_inc,
   input  logic             rx_err_dec,
   input  logic             bit_tick,
   input  logic             bus_level,
   output logic [1:0]       conf_state,
   output logic [TEC_W-1:0] tx_errs,
   output logic [REC_W-1:0] rx_errs,
   output logic             warn,
   output logic             warn_rise,
   output logic             passive_rise,
   output logic             busoff_rise
);
   import fc_pkg::*;

   localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_LIMIT);
   localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(BUSOFF_LIMIT);
   localparam logic [TEC_W-1:0] TEC_WARN = TEC_W'(WARN_LEVEL);
   localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASSIVE_LIMIT);
   localparam logic [REC_W-1:0] REC_WARN = REC_W'(WARN_LEVEL);
   localparam int NEV = 3;

   // elaboration-time parameter checks
   if ((1 << TEC_W) - 1 <= BUSOFF_LIMIT) begin : g_bad_tec
      $error("TEC_W too narrow to exceed BUSOFF_LIMIT");
   end
   if ((1 << REC_W) - 1 <= PASSIVE_LIMIT) begin : g_bad_rec
      $error("REC_W too narrow to exceed PASSIVE_LIMIT");
   end
   if (WARN_LEVEL > PASSIVE_LIMIT || PASSIVE_LIMIT >= BUSOFF_LIMIT) begin : g_bad_lim
      $error("limits must satisfy WARN <= PASSIVE < BUSOFF");
   end
   if (RUN_BITS < 1 || RUN_COUNT < 1) begin : g_bad_run
      $error("recovery run parameters must be positive");
   end

   fc_state_e        st_q, st_d;
   logic             in_off, recovered, warn_q, warn_d;
   logic [TEC_W-1:0] tec_d;
   logic [REC_W-1:0] rec_d;

   assign in_off = (st_q == FC_BUSOFF);

   fc_err_counter #(.W(TEC_W)) u_tec (
      .clk(clk), .rst(rst), .clr(recovered), .hold(in_off),
      .inc(tx_err_inc), .dec(tx_err_dec), .cnt_q(tx_errs), .cnt_d(tec_d)
   );

   fc_err_counter #(.W(REC_W)) u_rec (
      .clk(clk), .rst(rst), .clr(recovered), .hold(in_off),
      .inc(rx_err_inc), .dec(rx_err_dec), .cnt_q(rx_errs), .cnt_d(rec_d)
   );

   fc_idle_tracker #(.RUN_BITS(RUN_BITS), .RUN_COUNT(RUN_COUNT)) u_idle (
      .clk(clk), .rst(rst), .arm(in_off), .bit_tick(bit_tick),
      .recessive(bus_level), .done(recovered)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         FC_ACTIVE: begin
            if (tec_d > TEC_OFF)                           st_d = FC_BUSOFF;
            else if (tec_d > TEC_PASS || rec_d > REC_PASS) st_d = FC_PASSIVE;
         end
         FC_PASSIVE: begin
            if (tec_d > TEC_OFF)                             st_d = FC_BUSOFF;
            else if (tec_d <= TEC_PASS && rec_d <= REC_PASS) st_d = FC_ACTIVE;
         end
         FC_BUSOFF: begin
            if (recovered) st_d = FC_ACTIVE;
         end
         default: st_d = FC_ACTIVE;
      endcase
   end

   assign warn_d = (tec_d >= TEC_WARN) || (rec_d >= REC_WARN);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= FC_ACTIVE;
         warn_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         warn_q <= warn_d;
      end
   end

   // entry pulses: one flop per event, set on a rising condition
   logic [NEV-1:0] ev_now, ev_next, rise_q;
   assign ev_now  = {warn_q, st_q == FC_PASSIVE, st_q == FC_BUSOFF};
   assign ev_next = {warn_d, st_d == FC_PASSIVE, st_d == FC_BUSOFF};

   for (genvar i = 0; i < NEV; i++) begin : g_rise
      always_ff @(posedge clk) begin
         if (rst) rise_q[i] <= 1'b0;
         else     rise_q[i] <= ev_next[i] & ~ev_now[i];
      end
   end

   assign conf_state   = st_q;
   assign warn         = warn_q;
   assign warn_rise    = rise_q[2];
   assign passive_rise = rise_q[1];
   assign busoff_rise  = rise_q[0];
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
   parameter int TEC_W         = 9,
   parameter int REC_W         = 8,
   parameter int WARN_LEVEL    = 96,
   parameter int PASSIVE_LIMIT = 127,
   parameter int BUSOFF_LIMIT  = 255
) (
   input logic             clk,
   input logic             rst,
   input logic             tx_err_inc,
   input logic             tx_err_dec,
   input logic             rx_err_inc,
   input logic             rx_err_dec,
   input logic [1:0]       conf_state,
   input logic [TEC_W-1:0] tx_errs,
   input logic [REC_W-1:0] rx_errs,
   input logic             warn,
   input logic             warn_rise,
   input logic             passive_rise,
   input logic             busoff_rise
);
   localparam logic [1:0] S_ACT = 2'b00;
   localparam logic [1:0] S_PAS = 2'b01;
   localparam logic [1:0] S_OFF = 2'b10;
   localparam logic [TEC_W-1:0] T_PASS = TEC_W'(PASSIVE_LIMIT);
   localparam logic [TEC_W-1:0] T_OFF  = TEC_W'(BUSOFF_LIMIT);
   localparam logic [TEC_W-1:0] T_WARN = TEC_W'(WARN_LEVEL);
   localparam logic [REC_W-1:0] R_PASS = REC_W'(PASSIVE_LIMIT);
   localparam logic [REC_W-1:0] R_WARN = REC_W'(WARN_LEVEL);
   localparam logic [REC_W-1:0] R_MAX  = '1;

   logic rst_q;
   always_ff @(posedge clk) rst_q <= rst;

   always_ff @(posedge clk) begin
      if (rst_q) begin
         a_r1_reset_state: assert (conf_state == S_ACT && tx_errs == '0 && rx_errs == '0
                                   && !warn && !warn_rise && !passive_rise && !busoff_rise);
      end
   end

   a_r2_rx_inc: assert property (@(posedge clk) disable iff (rst)
      (conf_state != S_OFF && rx_err_inc && !rx_err_dec && rx_errs != R_MAX)
      |=> rx_errs == $past(rx_errs) + REC_W'(1));

   a_r2_tx_dec: assert property (@(posedge clk) disable iff (rst)
      (conf_state != S_OFF && tx_err_dec && !tx_err_inc && tx_errs != '0)
      |=> tx_errs == $past(tx_errs) - TEC_W'(1));

   a_r3_rec_saturates: assert property (@(posedge clk) disable iff (rst)
      (conf_state != S_OFF && rx_errs == R_MAX && !rx_err_dec) |=> rx_errs == R_MAX);

   a_r4_active_bounds: assert property (@(posedge clk) disable iff (rst)
      conf_state == S_ACT |-> (tx_errs <= T_PASS && rx_errs <= R_PASS));

   a_r5_passive_bounds: assert property (@(posedge clk) disable iff (rst)
      conf_state == S_PAS |-> ((tx_errs > T_PASS || rx_errs > R_PASS) && tx_errs <= T_OFF));

   a_r6_high_tec_offline: assert property (@(posedge clk) disable iff (rst)
      tx_errs > T_OFF |-> conf_state == S_OFF);

   a_r7_offline_frozen: assert property (@(posedge clk) disable iff (rst)
      conf_state == S_OFF |=>
         ((conf_state == S_OFF && $stable(tx_errs) && $stable(rx_errs)) ||
          (conf_state == S_ACT && tx_errs == '0 && rx_errs == '0)));

   a_r8_recover_cleared: assert property (@(posedge clk) disable iff (rst)
      ($past(conf_state) == S_OFF && conf_state == S_ACT) |-> (tx_errs == '0 && rx_errs == '0));

   a_r10_warn_level: assert property (@(posedge clk) disable iff (rst)
      warn == (tx_errs >= T_WARN || rx_errs >= R_WARN));

   a_r11_passive_pulse: assert property (@(posedge clk) disable iff (rst)
      $rose(conf_state == S_PAS) |-> passive_rise);

   a_r11_busoff_pulse: assert property (@(posedge clk) disable iff (rst)
      busoff_rise |-> (conf_state == S_OFF && $past(conf_state) != S_OFF));

   a_r11_warn_pulse: assert property (@(posedge clk) disable iff (rst)
      warn_rise |-> (warn && !$past(warn)));
endmodule

bind can_fault_confine fc_checker #(
   .TEC_W(TEC_W), .REC_W(REC_W), .WARN_LEVEL(WARN_LEVEL),
   .PASSIVE_LIMIT(PASSIVE_LIMIT), .BUSOFF_LIMIT(BUSOFF_LIMIT)
) u_fc_chk (
   .clk(clk), .rst(rst),
   .tx_err_inc(tx_err_inc), .tx_err_dec(tx_err_dec),
   .rx_err_inc(rx_err_inc), .rx_err_dec(rx_err_dec),
   .conf_state(conf_state), .tx_errs(tx_errs), .rx_errs(rx_errs),
   .warn(warn), .warn_rise(warn_rise),
   .passive_rise(passive_rise), .busoff_rise(busoff_rise)
);

// File: tb/tb_can_fault_confine.sv
`timescale 1ns/1ps
module tb_can_fault_confine;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ti = 0, td = 0, ri = 0, rd = 0, bt = 0, bl = 1;
   logic [1:0] conf_state;
   logic [8:0] tx_errs;
   logic [7:0] rx_errs;
   logic       warn, warn_rise, passive_rise, busoff_rise;

   int errors = 0, checks = 0;
   bit finished = 0;

   // reference model state
   int m_st, m_tec, m_rec, m_bit, m_run;
   bit m_warn, m_wr, m_pr, m_br;

   always #5 clk = ~clk;

   can_fault_confine dut (
      .clk(clk), .rst(rst),
      .tx_err_inc(ti), .tx_err_dec(td), .rx_err_inc(ri), .rx_err_dec(rd),
      .bit_tick(bt), .bus_level(bl),
      .conf_state(conf_state), .tx_errs(tx_errs), .rx_errs(rx_errs),
      .warn(warn), .warn_rise(warn_rise),
      .passive_rise(passive_rise), .busoff_rise(busoff_rise)
   );

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit warn_of(int t, int r);
      return (t >= 96) || (r >= 96);
   endfunction

   function automatic int state_of(int t, int r);
      if (t > 255) return 2;
      if (t > 127 || r > 127) return 1;
      return 0;
   endfunction

   task automatic model_reset();
      m_st = 0; m_tec = 0; m_rec = 0; m_bit = 0; m_run = 0;
      m_warn = 0; m_wr = 0; m_pr = 0; m_br = 0;
   endtask

   task automatic model_step(bit a, bit b, bit c, bit d, bit tick, bit lvl);
      int  old_st = m_st;
      bit  old_w  = m_warn;
      bit  fin    = 0;
      if (m_st == 2) begin
         if (tick) begin
            if (!lvl) m_bit = 0;
            else if (m_bit == 10) begin
               m_bit = 0;
               if (m_run == 127) fin = 1; else m_run++;
            end else m_bit++;
         end
         if (fin) begin
            m_st = 0; m_tec = 0; m_rec = 0; m_bit = 0; m_run = 0;
         end
      end else begin
         if (a && !b && m_tec < 511) m_tec++;
         else if (b && !a && m_tec > 0) m_tec--;
         if (c && !d && m_rec < 255) m_rec++;
         else if (d && !c && m_rec > 0) m_rec--;
         m_st = state_of(m_tec, m_rec);
      end
      m_warn = warn_of(m_tec, m_rec);
      m_wr = m_warn && !old_w;
      m_pr = (m_st == 1) && (old_st != 1);
      m_br = (m_st == 2) && (old_st != 2);
   endtask

   task automatic compare_model();
      check("R4 state vs model", conf_state, m_st);
      check("R2 tx count vs model", tx_errs, m_tec);
      check("R2 rx count vs model", rx_errs, m_rec);
      check("R10 warn vs model", warn, m_warn);
      check("R11 pulses vs model", {warn_rise, passive_rise, busoff_rise},
            {m_wr, m_pr, m_br});
   endtask

   task automatic step(bit a, bit b, bit c, bit d, bit tick, bit lvl);
      @(negedge clk);
      ti = a; td = b; ri = c; rd = d; bt = tick; bl = lvl;
      @(posedge clk);
      #1;
      model_step(a, b, c, d, tick, lvl);
      compare_model();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1; ti = 0; td = 0; ri = 0; rd = 0; bt = 0; bl = 1;
      repeat (3) @(posedge clk);
      #1;
      model_reset();
      check("R1 reset state", conf_state, 0);
      check("R1 reset tx count", tx_errs, 0);
      check("R1 reset rx count", rx_errs, 0);
      check("R1 reset flags", {warn, warn_rise, passive_rise, busoff_rise}, 0);
      @(negedge clk);
      rst = 0;
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24680));
      model_reset();
      do_reset();

      // R2 directed steps
      step(0, 0, 0, 1, 0, 1);
      check("R2 decrement at zero", rx_errs, 0);
      step(0, 0, 1, 0, 0, 1);
      check("R2 single increment", rx_errs, 1);
      step(0, 0, 1, 1, 0, 1);
      check("R2 inc and dec together", rx_errs, 1);
      step(1, 0, 0, 0, 0, 1);
      step(0, 1, 0, 0, 0, 1);
      check("R2 tx inc then dec", tx_errs, 0);

      // R10/R4/R5/R3 on the receive counter
      while (rx_errs < 95) step(0, 0, 1, 0, 0, 1);
      check("R10 warn low at 95", warn, 0);
      step(0, 0, 1, 0, 0, 1);
      check("R10 warn high at 96", warn, 1);
      check("R11 warn pulse", warn_rise, 1);
      step(0, 0, 0, 0, 0, 1);
      check("R11 warn pulse one cycle", warn_rise, 0);
      while (rx_errs < 127) step(0, 0, 1, 0, 0, 1);
      check("R4 still active at 127", conf_state, 0);
      step(0, 0, 1, 0, 0, 1);
      check("R4 passive at 128", conf_state, 1);
      check("R11 passive pulse", passive_rise, 1);
      step(0, 0, 0, 0, 0, 1);
      check("R11 passive pulse one cycle", passive_rise, 0);
      step(0, 0, 0, 1, 0, 1);
      check("R5 active at 127", conf_state, 0);
      while (rx_errs < 255) step(0, 0, 1, 0, 0, 1);
      step(0, 0, 1, 0, 0, 1);
      check("R3 saturates at 255", rx_errs, 255);

      // bus-off entry and recovery
      do_reset();
      while (tx_errs < 255) step(1, 0, 0, 0, 0, 1);
      check("R5 passive at tec 255", conf_state, 1);
      step(1, 0, 0, 0, 0, 1);
      check("R6 bus-off at 256", conf_state, 2);
      check("R11 bus-off pulse", busoff_rise, 1);
      step(0, 1, 1, 0, 0, 1);
      check("R7 tx frozen", tx_errs, 256);
      check("R7 rx frozen", rx_errs, 0);
      check("R11 bus-off pulse one cycle", busoff_rise, 0);
      for (int r = 0; r < 127; r++)
         for (int k = 0; k < 11; k++) begin
            step(0, 0, 0, 0, 1, 1);
            if (k == 5) step(1, 0, 1, 0, 0, 0); // no bit strobe: run continues
         end
      check("R8 still bus-off after 127 runs", conf_state, 2);
      for (int k = 0; k < 10; k++) step(0, 0, 0, 0, 1, 1);
      step(0, 0, 0, 0, 1, 0);
      for (int k = 0; k < 10; k++) step(0, 0, 0, 0, 1, 1);
      check("R9 dominant restarted run", conf_state, 2);
      step(0, 0, 0, 0, 1, 1);
      check("R9 completed runs kept, recovered", conf_state, 0);
      check("R8 tx cleared", tx_errs, 0);
      check("R8 rx cleared", rx_errs, 0);

      // constrained random phase
      do_reset();
      for (int n = 0; n < 12000; n++) begin
         int unsigned v = $urandom;
         step((v % 100) < 55, ((v >> 7) % 100) < 25,
              ((v >> 14) % 100) < 45, ((v >> 21) % 100) < 30,
              ((v >> 3) % 10) < 8, ((v >> 10) % 100) < 97);
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule